// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

A synchronous binary counter that can be preset from a parallel data word and chained with identical stages into a wider counter. All state bits update together on the rising clock edge. A low on the load input copies the data word into the counter. The counter steps up by one only when both of its count enables are high. If neither load nor count applies, the value is held.

The active-low clear input zeroes the counter. A compile-time parameter decides whether the clear acts at once, asynchronously, or at the next rising edge. The terminal-count flag is high when the counter holds all ones and the trickle enable is high. To build a wider counter, connect each stage's flag to the trickle enable of the next stage, drive every parallel enable from one common count request, and run all stages on one clock.

Top module: `cascade_counter`

## Requirements
- R1: The width is the parameter WIDTH (default 4). Every bit of count_o changes only on a rising edge of clk_i, except for an asynchronous clear.
- R2: When load_ni is 0 at a rising edge and clear is inactive, count_o takes data_i, whatever the values of cnt_en_p_i and cnt_en_t_i.
- R3: With ASYNC_CLR=1, rst_ni=0 forces count_o to 0 at once, with no clock edge needed, whatever the values of load_ni and the enables.
- R4: With ASYNC_CLR=0, rst_ni=0 leaves count_o unchanged until the next rising edge, which sets it to 0 even when load_ni=0 and both enables are 1.
- R5: With load_ni=1, count_o goes up by one at a rising edge only when cnt_en_p_i=1 and cnt_en_t_i=1. In every other case it holds its value.
- R6: A count step from all ones gives 0.
- R7: tc_o is 1 exactly when cnt_en_t_i=1 and count_o is all ones. It follows those inputs in the same cycle, with no register delay.
- R8: Two 4-bit stages behave as one 8-bit counter when the low stage's tc_o drives the high stage's cnt_en_t_i and both share clk_i and cnt_en_p_i. The high stage is the upper nibble.
- R9: At a rising edge the priority is clear, then load, then count, then hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Active-low clear (asynchronous or synchronous, per ASYNC_CLR) |
| load_ni | input | 1 | Active-low parallel load |
| data_i | input | WIDTH | Preset value |
| cnt_en_p_i | input | 1 | Parallel count enable, active high |
| cnt_en_t_i | input | 1 | Trickle count enable, active high; also gates tc_o |
| count_o | output | WIDTH | Counter value |
| tc_o | output | 1 | Terminal-count flag |

## Verification
Clear, load and count requests can all be active at the same rising edge. The bench raises them together through directed cases and through random stimulus in which each control toggles on its own. At each edge, a bench model that applies the clear, load, count, hold priority predicts the result. For the synchronous variant, the bench also checks before the edge that a pending clear has not yet changed the count, and that the following edge zeroes it even though a load is being requested.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic    clr_req_i,
  input  logic    load_ni,
  input  logic    en_p_i,
  input  logic    en_t_i,
  output cnt_op_e op_o
);
  // R9: clear > load > count > hold
  always_comb begin
    if (clr_req_i)              op_o = OP_CLEAR;
    else if (!load_ni)          op_o = OP_LOAD;
    else if (en_p_i && en_t_i)  op_o = OP_COUNT;
    else                        op_o = OP_HOLD;
  end
endmodule

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  cnt_op_e          op_i,
  input  logic [WIDTH-1:0] q_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] nxt_o
);
  always_comb begin
    unique case (op_i)
      OP_CLEAR: nxt_o = '0;
      OP_LOAD:  nxt_o = d_i;
      OP_COUNT: nxt_o = q_i + WIDTH'(1);  // wraps from all ones
      default:  nxt_o = q_i;
    endcase
  end
endmodule

// File: rtl/cnt_reg.sv
module cnt_reg #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] nxt_i,
  output logic [WIDTH-1:0] q_o
);
  if (ASYNC_CLR) begin : g_async
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= nxt_i;
    end
    a_r3_async_clear: assert property (@(posedge clk_i) !rst_ni |-> (q_o == '0));
  end else begin : g_sync
    always_ff @(posedge clk_i) q_o <= nxt_i;
    a_r4_sync_clear: assert property (@(posedge clk_i) !rst_ni |=> (q_o == '0));
  end
endmodule

// File: rtl/cnt_tc.sv
module cnt_tc #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             en_t_i,
  output logic             tc_o
);
  // look-ahead chain: all ones seen so far, seeded by trickle enable
  logic [WIDTH:0] chain;
  assign chain[0] = en_t_i;
  for (genvar i = 0; i < WIDTH; i++) begin : g_chain
    assign chain[i+1] = chain[i] & q_i[i];
  end
  assign tc_o = chain[WIDTH];
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             cnt_en_p_i,
  input  logic             cnt_en_t_i,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_o
);
  cnt_op_e          op;
  logic [WIDTH-1:0] nxt;
  logic             clr_req;

  // async clear acts in the register; sync clear enters the op select
  assign clr_req = ASYNC_CLR ? 1'b0 : !rst_ni;

  cnt_ctrl u_ctrl (
    .clr_req_i (clr_req),
    .load_ni   (load_ni),
    .en_p_i    (cnt_en_p_i),
    .en_t_i    (cnt_en_t_i),
    .op_o      (op)
  );

  cnt_next #(.WIDTH(WIDTH)) u_next (
    .op_i  (op),
    .q_i   (count_o),
    .d_i   (data_i),
    .nxt_o (nxt)
  );

  cnt_reg #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nxt_i  (nxt),
    .q_o    (count_o)
  );

  cnt_tc #(.WIDTH(WIDTH)) u_tc (
    .q_i    (count_o),
    .en_t_i (cnt_en_t_i),
    .tc_o   (tc_o)
  );

  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> (count_o == $past(data_i)));
  a_r5_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && cnt_en_p_i && cnt_en_t_i) |=> (count_o == $past(count_o) + WIDTH'(1)));
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !(cnt_en_p_i && cnt_en_t_i)) |=> $stable(count_o));
  a_r6_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && cnt_en_p_i && load_ni) |=> (count_o == '0));
  a_r7_tc_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> cnt_en_t_i);
endmodule

// File: tb/tb_cascade_counter.sv
module tb_cascade_counter;
  localparam int W = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic         rst_ni = 1'b1, srst_n = 1'b1, crst_n = 1'b1;
  logic         load_n = 1'b1, en_p = 1'b0, en_t = 1'b0, c_en = 1'b0;
  logic [W-1:0] data = '0;
  logic [W-1:0] q_a, q_s, q_lo, q_hi;
  logic         tc_a, tc_s, tc_lo, tc_hi;

  cascade_counter #(.WIDTH(W), .ASYNC_CLR(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .load_ni(load_n), .data_i(data),
    .cnt_en_p_i(en_p), .cnt_en_t_i(en_t), .count_o(q_a), .tc_o(tc_a));
  cascade_counter #(.WIDTH(W), .ASYNC_CLR(1'b0)) dut_s (
    .clk_i(clk), .rst_ni(srst_n), .load_ni(load_n), .data_i(data),
    .cnt_en_p_i(en_p), .cnt_en_t_i(en_t), .count_o(q_s), .tc_o(tc_s));
  cascade_counter #(.WIDTH(W), .ASYNC_CLR(1'b1)) dut_lo (
    .clk_i(clk), .rst_ni(crst_n), .load_ni(1'b1), .data_i('0),
    .cnt_en_p_i(c_en), .cnt_en_t_i(1'b1), .count_o(q_lo), .tc_o(tc_lo));
  cascade_counter #(.WIDTH(W), .ASYNC_CLR(1'b1)) dut_hi (
    .clk_i(clk), .rst_ni(crst_n), .load_ni(1'b1), .data_i('0),
    .cnt_en_p_i(c_en), .cnt_en_t_i(tc_lo), .count_o(q_hi), .tc_o(tc_hi));

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [W-1:0] m_a = '0, m_s = '0;
  logic [7:0]   m_c = '0;

  function automatic logic [W-1:0] nxt(logic [W-1:0] q, logic clr, logic ld_n,
                                       logic [W-1:0] d, logic p, logic t);
    if (clr)        return '0;
    else if (!ld_n) return d;
    else if (p && t) return q + 1'b1;
    else            return q;
  endfunction

  function automatic logic tc_of(logic [W-1:0] q, logic t);
    return t && (q == {W{1'b1}});
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // drive at negedge, check tc and async clear, then edge and check counts
  task automatic step(logic ra, logic rs, logic ld, logic [W-1:0] d, logic p, logic t);
    @(negedge clk);
    rst_ni = ra; srst_n = rs; load_n = ld; data = d; en_p = p; en_t = t;
    #1;
    if (!ra) m_a = '0;
    chk("R3 async clear immediate", q_a, m_a);
    chk("R4 sync count before edge", q_s, m_s);
    chk("R7 tc async inst", tc_a, tc_of(m_a, t));
    chk("R7 tc sync inst", tc_s, tc_of(m_s, t));
    @(posedge clk);
    m_a = ra ? nxt(m_a, 1'b0, ld, d, p, t) : '0;
    m_s = nxt(m_s, !rs, ld, d, p, t);
    #1;
    chk("R9 async inst after edge", q_a, m_a);
    chk("R9 sync inst after edge", q_s, m_s);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned seed = $urandom(32'd1234);
    #2;
    rst_ni = 1'b0; srst_n = 1'b0; crst_n = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R1 reset state async", q_a, 0);
    chk("R4 reset state sync", q_s, 0);
    chk("R1 reset state cascade", {q_hi, q_lo}, 0);
    m_a = '0; m_s = '0;

    // R2: load ignores enables
    step(1, 1, 0, 4'hA, 0, 0);
    chk("R2 load no enables", q_a, 4'hA);
    step(1, 1, 0, 4'h3, 1, 1);
    chk("R2 load over enables", q_s, 4'h3);
    // R5: one enable alone holds
    step(1, 1, 1, 4'h0, 1, 0);
    chk("R5 hold en_t low", q_a, 4'h3);
    step(1, 1, 1, 4'h0, 0, 1);
    chk("R5 hold en_p low", q_a, 4'h3);
    step(1, 1, 1, 4'h0, 1, 1);
    chk("R5 count both high", q_a, 4'h4);
    // R6/R7: all ones, tc, wrap
    step(1, 1, 0, 4'hF, 0, 0);
    step(1, 1, 1, 4'h0, 0, 0);
    chk("R7 tc low with en_t low", tc_a, 0);
    @(negedge clk); en_t = 1'b1; #1;
    chk("R7 tc same cycle", tc_a, 1);
    step(1, 1, 1, 4'h0, 1, 1);
    chk("R6 wrap to zero", q_a, 0);
    chk("R6 wrap sync inst", q_s, 0);
    // R3: async clear mid-cycle with no edge
    step(1, 1, 0, 4'h9, 0, 0);
    @(posedge clk); #2; rst_ni = 1'b0; #1;
    chk("R3 cleared without edge", q_a, 0);
    m_a = '0;
    // R4/R9: sync clear beats load and count
    step(0, 0, 0, 4'h7, 1, 1);
    chk("R4 sync clear beats load", q_s, 0);
    chk("R9 async held clear vs load", q_a, 0);
    step(1, 1, 0, 4'h6, 1, 1);
    chk("R9 load beats count", q_s, 4'h6);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r = $urandom();
      step(r[3:0] != 0, r[7:4] != 0, r[10:8] != 0, r[15:12], r[16] | r[17], r[18] | r[19]);
    end

    // R8: cascade as 8-bit counter
    @(negedge clk); crst_n = 1'b1; c_en = 1'b0; m_c = '0;
    for (int i = 0; i < 700; i++) begin
      logic go = (i % 7) != 3;
      @(negedge clk); c_en = go; #1;
      chk("R8 tc_hi at 255", tc_hi, (m_c == 8'hFF));
      @(posedge clk);
      if (go) m_c = m_c + 8'd1;
      #1;
      chk("R8 cascade value", {q_hi, q_lo}, m_c);
    end
    finish_run();
  end
endmodule